// File: doc/BRIEF.md
# Tag-Zeroing Double-Granule Store Unit

This unit decodes one memory-tagging store instruction and carries it out. The instruction clears two neighbouring 16-byte granules to zero and gives both the same 4-bit allocation tag. A 32-bit instruction word arrives with a one-cycle valid strobe. The unit drives the register-file read indices combinationally from that word. In the same cycle it takes the base value, the source value and the stack pointer. It then works out the granule address from one of three addressing modes. If the address is misaligned it faults, and nothing else happens. Otherwise it issues the two granule writes in order over a valid/ready port. It finishes, when the mode asks for it, with a one-cycle register writeback.

Control is held by a state machine with six states:
- `ST_IDLE`: waits for a recognised instruction.
- `ST_GRAN_LO`: the write of the first granule is pending.
- `ST_GRAN_HI`: the write of the second granule is pending.
- `ST_WBACK`: the one-cycle base writeback pulse.
- `ST_FAULT`: the one-cycle alignment-fault pulse.
- `ST_UNDEF`: the one-cycle undefined-instruction pulse.

Transitions:
- `ST_IDLE` moves to `ST_UNDEF` when the feature enable is low.
- `ST_IDLE` moves to `ST_FAULT` when the address is misaligned.
- `ST_IDLE` moves to `ST_GRAN_LO` otherwise.
- `ST_GRAN_LO` moves to `ST_GRAN_HI` when `mem_ready` is high.
- `ST_GRAN_HI` moves to `ST_WBACK` when `mem_ready` is high and the mode writes back. It returns to `ST_IDLE` when `mem_ready` is high and the mode does not.
- `ST_WBACK`, `ST_FAULT` and `ST_UNDEF` each return to `ST_IDLE` after one cycle.

Every instruction that is not recognised leaves the machine in `ST_IDLE`.

Top module: `tag_zero_pair_store`

## Requirements
- R1: An instruction is recognised only when word bits 31:21 equal 11011001111 and the mode field (bits 11:10) is not 00. Any other word, including mode 00, produces no write, no fault, no undefined flag and no writeback.
- R2: When a recognised instruction is accepted with `feat_en` low, `undef_ins` pulses for exactly one cycle, in the cycle after acceptance. No write, fault or writeback follows. This check takes precedence over the alignment check.
- R3: The offset is the signed 9-bit field at bits 20:12, sign-extended and multiplied by 16. The first write address is base plus offset for mode 11 (pre-index) and for mode 10 (plain offset). It is the base itself for mode 01 (post-index).
- R4: Exactly two writes are issued, in order. The second address is the first plus 16, and it is presented only after the first write has been accepted.
- R5: Both writes carry 128 bits of zero data, and both carry the tag taken from bits 59:56 of the source value.
- R6: An index of 31, in the base field (bits 9:5) or the source field (bits 4:0), selects `sp_value` in place of the register data. A writeback to base index 31 raises `wb_to_sp`.
- R7: When the low 4 bits of the first address are nonzero, `align_fault` pulses for one cycle, in the cycle after acceptance, and no write and no writeback occur. Because the offset is a multiple of 16, this is the same as a misaligned base, stack pointer included.
- R8: Mode 11 writes the first address back to the base register, and mode 01 writes back base plus offset. Mode 10 writes nothing back. When it occurs, the writeback is a one-cycle `wb_valid` pulse in the cycle after the second write is accepted, and it carries the base index.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` stays unchanged.
- R10: An instruction strobe that arrives while the unit is busy is ignored.
- R11: After reset, `mem_valid`, `wb_valid`, `align_fault` and `undef_ins` are low.
- R12: `rd_base_idx` and `rd_src_idx` follow word bits 9:5 and 4:0 combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Memory-tagging feature enable |
| ins_valid | input | 1 | Instruction strobe |
| ins_word | input | 32 | Instruction word |
| rd_base_idx | output | 5 | Base register read index |
| rd_src_idx | output | 5 | Source register read index |
| rf_base_data | input | 64 | Base register read data |
| rf_src_data | input | 64 | Source register read data |
| sp_value | input | 64 | Stack pointer value |
| mem_valid | output | 1 | Granule write request |
| mem_ready | input | 1 | Granule write accepted |
| mem_addr | output | 64 | Granule address |
| mem_data | output | 128 | Granule data (zero) |
| mem_tag | output | 4 | Allocation tag |
| wb_valid | output | 1 | Base writeback pulse |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Writeback value |
| align_fault | output | 1 | Alignment fault pulse |
| undef_ins | output | 1 | Undefined instruction pulse |

## Verification
The assertions assume the following about the inputs:
- The register data and the stack pointer are valid in the cycle that `ins_valid` is high.
- `mem_ready` is only meaningful while a request is pending.

The bench drives all operands in the strobe cycle and holds them there. It raises `mem_ready` only in response to an observed `mem_valid`, sometimes after deliberate stall cycles. The sweep covers every immediate in every mode, misaligned bases, stack-pointer selection, disabled features and strobes sent while the unit is busy.

// File: rtl/tzs_pkg.sv
package tzs_pkg;

    localparam int IMM_W = 9;
    localparam int IDX_W = 5;
    localparam logic [10:0] OPC_MATCH = 11'b11011001111;
    localparam logic [IDX_W-1:0] SP_IDX = '1;

    typedef enum logic [1:0] {
        AM_NONE = 2'b00,
        AM_POST = 2'b01,
        AM_OFFS = 2'b10,
        AM_PRE  = 2'b11
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRAN_LO,
        ST_GRAN_HI,
        ST_WBACK,
        ST_FAULT,
        ST_UNDEF
    } state_e;

    typedef struct packed {
        logic             hit;
        amode_e           mode;
        logic [IMM_W-1:0] imm;
        logic [IDX_W-1:0] base_idx;
        logic [IDX_W-1:0] src_idx;
    } dec_t;

endpackage

// File: rtl/tzs_decode.sv
module tzs_decode
    import tzs_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);

    logic opc_ok;
    logic mode_ok;

    always_comb begin
        opc_ok       = (word[31:21] == OPC_MATCH);
        mode_ok      = (word[11:10] != 2'b00);
        dec.hit      = opc_ok && mode_ok;
        dec.mode     = amode_e'(word[11:10]);
        dec.imm      = word[20:12];
        dec.base_idx = word[9:5];
        dec.src_idx  = word[4:0];
    end

endmodule

// File: rtl/tzs_agen.sv
module tzs_agen
    import tzs_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int GRAN_LOG2 = 4
) (
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [IMM_W-1:0]  imm,
    input  amode_e            mode,
    input  logic [ADDR_W-1:0] rf_base,
    input  logic [ADDR_W-1:0] sp_val,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              misaligned
);

    localparam int GRAN_BYTES = 1 << GRAN_LOG2;
    localparam int EXT_W      = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] base_val;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        base_val   = (base_idx == SP_IDX) ? sp_val : rf_base;
        offset     = {{EXT_W{imm[IMM_W-1]}}, imm} << GRAN_LOG2;
        sum        = base_val + offset;
        addr_lo    = (mode == AM_POST) ? base_val : sum;
        addr_hi    = addr_lo + ADDR_W'(GRAN_BYTES);
        wb_addr    = sum;
        misaligned = |addr_lo[GRAN_LOG2-1:0];
    end

endmodule

// File: rtl/tzs_ctrl.sv
module tzs_ctrl
    import tzs_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int GRAN_LOG2 = 4,
    parameter int TAG_W     = 4,
    localparam int DATA_W   = 8 << GRAN_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              feat_en,
    input  amode_e            mode,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic              misaligned,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [TAG_W-1:0]  mem_tag,
    output logic              wb_valid,
    output logic              wb_to_sp,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [ADDR_W-1:0] wb_data,
    output logic              align_fault,
    output logic              undef_ins
);

    localparam int GRAN_BYTES = 1 << GRAN_LOG2;

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] lo_q, hi_q, wba_q;
    logic [TAG_W-1:0]  tag_q;
    logic [IDX_W-1:0]  idx_q;
    logic              do_wb_q;
    logic              take;

    assign take = (state_q == ST_IDLE) && start;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!feat_en)        state_d = ST_UNDEF;
                    else if (misaligned) state_d = ST_FAULT;
                    else                 state_d = ST_GRAN_LO;
                end
            end
            ST_GRAN_LO: if (mem_ready) state_d = ST_GRAN_HI;
            ST_GRAN_HI: if (mem_ready) state_d = do_wb_q ? ST_WBACK : ST_IDLE;
            ST_WBACK:   state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            ST_UNDEF:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            wba_q   <= '0;
            tag_q   <= '0;
            idx_q   <= '0;
            do_wb_q <= 1'b0;
        end else if (take) begin
            lo_q    <= addr_lo;
            hi_q    <= addr_hi;
            wba_q   <= (mode == AM_PRE) ? addr_lo : wb_addr;
            tag_q   <= tag_in;
            idx_q   <= base_idx;
            do_wb_q <= (mode != AM_OFFS);
        end
    end

    always_comb begin
        mem_valid   = 1'b0;
        mem_addr    = lo_q;
        mem_data    = '0;
        mem_tag     = tag_q;
        wb_valid    = 1'b0;
        wb_to_sp    = (idx_q == SP_IDX);
        wb_idx      = idx_q;
        wb_data     = wba_q;
        align_fault = 1'b0;
        undef_ins   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_GRAN_LO: mem_valid = 1'b1;
            ST_GRAN_HI: begin
                mem_valid = 1'b1;
                mem_addr  = hi_q;
            end
            ST_WBACK:   wb_valid    = 1'b1;
            ST_FAULT:   align_fault = 1'b1;
            ST_UNDEF:   undef_ins   = 1'b1;
            default:    ;
        endcase
    end

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    a_r4_second_granule: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRAN_LO && mem_ready) |=>
            (mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(GRAN_BYTES)));

    a_r7_only_aligned_writes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[GRAN_LOG2-1:0] == '0));

    a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!mem_valid && !wb_valid && !undef_ins));

    a_r2_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        undef_ins |-> (!mem_valid && !wb_valid && !align_fault));

    a_r8_wb_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> $past(mem_valid && mem_ready));

    a_r8_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

endmodule

// File: rtl/tag_zero_pair_store.sv
module tag_zero_pair_store
    import tzs_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int GRAN_LOG2 = 4,
    parameter int TAG_W     = 4,
    parameter int TAG_LSB   = 56,
    localparam int DATA_W   = 8 << GRAN_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_en,
    input  logic              ins_valid,
    input  logic [31:0]       ins_word,
    output logic [4:0]        rd_base_idx,
    output logic [4:0]        rd_src_idx,
    input  logic [ADDR_W-1:0] rf_base_data,
    input  logic [ADDR_W-1:0] rf_src_data,
    input  logic [ADDR_W-1:0] sp_value,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [TAG_W-1:0]  mem_tag,
    output logic              wb_valid,
    output logic              wb_to_sp,
    output logic [4:0]        wb_idx,
    output logic [ADDR_W-1:0] wb_data,
    output logic              align_fault,
    output logic              undef_ins
);

    dec_t              dec;
    logic [ADDR_W-1:0] addr_lo, addr_hi, wb_addr;
    logic              misaligned;
    logic [TAG_W-1:0]  tag_sel;
    logic              start;

    tzs_decode u_decode (
        .word (ins_word),
        .dec  (dec)
    );

    assign rd_base_idx = dec.base_idx;
    assign rd_src_idx  = dec.src_idx;
    assign start       = ins_valid && dec.hit;
    assign tag_sel     = (dec.src_idx == SP_IDX) ? sp_value[TAG_LSB +: TAG_W]
                                                 : rf_src_data[TAG_LSB +: TAG_W];

    tzs_agen #(
        .ADDR_W    (ADDR_W),
        .GRAN_LOG2 (GRAN_LOG2)
    ) u_agen (
        .base_idx   (dec.base_idx),
        .imm        (dec.imm),
        .mode       (dec.mode),
        .rf_base    (rf_base_data),
        .sp_val     (sp_value),
        .addr_lo    (addr_lo),
        .addr_hi    (addr_hi),
        .wb_addr    (wb_addr),
        .misaligned (misaligned)
    );

    tzs_ctrl #(
        .ADDR_W    (ADDR_W),
        .GRAN_LOG2 (GRAN_LOG2),
        .TAG_W     (TAG_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .feat_en     (feat_en),
        .mode        (dec.mode),
        .base_idx    (dec.base_idx),
        .addr_lo     (addr_lo),
        .addr_hi     (addr_hi),
        .wb_addr     (wb_addr),
        .misaligned  (misaligned),
        .tag_in      (tag_sel),
        .mem_ready   (mem_ready),
        .mem_valid   (mem_valid),
        .mem_addr    (mem_addr),
        .mem_data    (mem_data),
        .mem_tag     (mem_tag),
        .wb_valid    (wb_valid),
        .wb_to_sp    (wb_to_sp),
        .wb_idx      (wb_idx),
        .wb_data     (wb_data),
        .align_fault (align_fault),
        .undef_ins   (undef_ins)
    );

    a_r12_read_indices: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_base_idx == ins_word[9:5]) && (rd_src_idx == ins_word[4:0]));

    a_r1_no_start_no_activity: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && !wb_valid && !align_fault && !undef_ins && !start)
            |=> (!mem_valid && !align_fault && !undef_ins));

endmodule

// File: tb/test_tag_zero_pair_store.sv
module test_tag_zero_pair_store;

    localparam int CLK_PERIOD = 10;
    localparam logic [10:0] OPC = 11'b11011001111;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         feat_en = 1'b1;
    logic         ins_valid = 1'b0;
    logic [31:0]  ins_word = '0;
    logic [4:0]   rd_base_idx, rd_src_idx;
    logic [63:0]  rf_base_data = '0, rf_src_data = '0, sp_value = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic [3:0]   mem_tag;
    logic         wb_valid, wb_to_sp;
    logic [4:0]   wb_idx;
    logic [63:0]  wb_data;
    logic         align_fault, undef_ins;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_zero_pair_store i_tag_zero_pair_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .feat_en      (feat_en),
        .ins_valid    (ins_valid),
        .ins_word     (ins_word),
        .rd_base_idx  (rd_base_idx),
        .rd_src_idx   (rd_src_idx),
        .rf_base_data (rf_base_data),
        .rf_src_data  (rf_src_data),
        .sp_value     (sp_value),
        .mem_valid    (mem_valid),
        .mem_ready    (mem_ready),
        .mem_addr     (mem_addr),
        .mem_data     (mem_data),
        .mem_tag      (mem_tag),
        .wb_valid     (wb_valid),
        .wb_to_sp     (wb_to_sp),
        .wb_idx       (wb_idx),
        .wb_data      (wb_data),
        .align_fault  (align_fault),
        .undef_ins    (undef_ins)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] mode, input logic [8:0] imm,
                                       input logic [4:0] b, input logic [4:0] s);
        return {OPC, imm, mode, b, s};
    endfunction

    task automatic run_ins(input logic [31:0] w, input logic [63:0] bval, input logic [63:0] sval,
                           input logic [63:0] spv, input bit feat, input bit stall, input bit intrude);
        logic [4:0]  bidx = w[9:5];
        logic [4:0]  sidx = w[4:0];
        logic [1:0]  mode = w[11:10];
        logic [8:0]  imm  = w[20:12];
        bit          hit  = (w[31:21] == OPC) && (mode != 2'b00);
        logic [63:0] base = (bidx == 5'd31) ? spv : bval;
        logic [63:0] src  = (sidx == 5'd31) ? spv : sval;
        logic [63:0] off  = {{55{imm[8]}}, imm} << 4;
        logic [63:0] a0   = (mode == 2'b01) ? base : base + off;
        logic [63:0] a1   = a0 + 64'd16;
        logic [63:0] ewbv = (mode == 2'b11) ? a0 : base + off;
        bit e_undef = hit && !feat;
        bit e_fault = hit && feat && (a0[3:0] != 4'h0);
        bit e_ok    = hit && feat && !e_fault;
        int ewr = e_ok ? 2 : 0;
        int ewb = (e_ok && mode != 2'b10) ? 1 : 0;
        string rq = intrude ? "R10" : !hit ? "R1" : e_undef ? "R2" : e_fault ? "R7" : "R4";
        logic [63:0]  wa [2];
        logic [127:0] wd [2];
        logic [3:0]   wt [2];
        int wk [2];
        int nwr = 0, nwb = 0, nf = 0, nu = 0, wbk = -1, fk = -1, uk = -1;
        logic [63:0] wbd = '0;
        logic [4:0]  wbi = '0;
        bit          wbs = 1'b0;
        bit          hold = 1'b0;
        logic [63:0] prev = '0;
        @(negedge clk);
        ins_word = w; rf_base_data = bval; rf_src_data = sval; sp_value = spv;
        feat_en = feat; ins_valid = 1'b1; mem_ready = 1'b0;
        #1;
        chk(rd_base_idx == bidx && rd_src_idx == sidx, "R12", {rd_base_idx, rd_src_idx}, {bidx, sidx});
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == 0) begin
                ins_valid = intrude;
                if (intrude) ins_word = mk(2'b11, 9'd5, 5'd2, 5'd2);
            end else if (k == 1) begin
                ins_valid = 1'b0;
            end
            if (hold)
                chk(mem_valid && mem_addr == prev, "R9", mem_addr, prev);
            if (mem_valid) begin
                mem_ready = stall ? (k % 3 == 2) : 1'b1;
                hold = !mem_ready;
                prev = mem_addr;
                if (mem_ready) begin
                    if (nwr < 2) begin
                        wa[nwr] = mem_addr; wd[nwr] = mem_data; wt[nwr] = mem_tag; wk[nwr] = k;
                    end
                    nwr++;
                end
            end else begin
                mem_ready = 1'b0;
                hold = 1'b0;
            end
            if (wb_valid) begin
                nwb++; wbk = k; wbd = wb_data; wbi = wb_idx; wbs = wb_to_sp;
            end
            if (align_fault) begin nf++; fk = k; end
            if (undef_ins)   begin nu++; uk = k; end
        end
        mem_ready = 1'b0;
        chk(nwr == ewr, rq, nwr, ewr);
        if (e_ok && nwr == 2) begin
            chk(wa[0] == a0, "R3", wa[0], a0);
            chk(wa[1] == a1 && wk[1] > wk[0], "R4", wa[1], a1);
            chk(wd[0] == '0 && wd[1] == '0, "R5", wd[0] | wd[1], 0);
            chk(wt[0] == src[59:56] && wt[1] == src[59:56], "R5", {wt[0], wt[1]}, {src[59:56], src[59:56]});
            if (bidx == 5'd31 || sidx == 5'd31)
                chk(wa[0] == a0 && wt[0] == src[59:56], "R6", {wa[0], wt[0]}, {a0, src[59:56]});
        end
        chk(nwb == ewb, "R8", nwb, ewb);
        if (ewb == 1 && nwb == 1 && nwr == 2) begin
            chk(wbd == ewbv, "R8", wbd, ewbv);
            chk(wbi == bidx && wbk == wk[1] + 1, "R8", {wbi, 8'(wbk)}, {bidx, 8'(wk[1] + 1)});
            chk(wbs == (bidx == 5'd31), "R6", wbs, (bidx == 5'd31));
        end
        chk(nf == (e_fault ? 1 : 0) && (!e_fault || fk == 0), "R7", {8'(nf), 8'(fk)}, {8'(e_fault), 8'd0});
        chk(nu == (e_undef ? 1 : 0) && (!e_undef || uk == 0), "R2", {8'(nu), 8'(uk)}, {8'(e_undef), 8'd0});
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] bbase = 64'h0000_4000_0000_8000;
        repeat (3) @(negedge clk);
        chk(!mem_valid && !wb_valid && !align_fault && !undef_ins, "R11",
            {mem_valid, wb_valid, align_fault, undef_ins}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_valid && !wb_valid && !align_fault && !undef_ins, "R11",
            {mem_valid, wb_valid, align_fault, undef_ins}, 0);

        // R3 R4 R5 R8: every immediate in every mode
        for (int m = 1; m < 4; m++)
            for (int i = 0; i < 512; i++)
                run_ins(mk(2'(m), 9'(i), 5'd3, 5'd7), bbase + 64'(i * 48),
                        {4'h0, 4'(i), 56'h00_1234_5678_9abc}, 64'hdead_0000_0000_0010, 1'b1, i[0], 1'b0);

        // R6: stack pointer as base and as source
        for (int m = 1; m < 4; m++)
            for (int i = 0; i < 16; i++) begin
                run_ins(mk(2'(m), 9'(i * 31), 5'd31, 5'd4), 64'h1111_0000_0000_0000,
                        64'h0500_0000_0000_0000, 64'h0000_7fff_0000_0ff0, 1'b1, 1'b0, 1'b0);
                run_ins(mk(2'(m), 9'(i * 29), 5'd9, 5'd31), bbase,
                        64'h0000_0000_0000_0000, 64'h0c00_0000_0001_0000, 1'b1, i[0], 1'b0);
                run_ins(mk(2'(m), 9'(i), 5'd31, 5'd31), 64'h0, 64'h0,
                        64'h0a00_0000_0002_0000 + 64'(i * 16), 1'b1, 1'b0, 1'b0);
            end

        // R7: misaligned base, general register and stack pointer
        for (int m = 1; m < 4; m++)
            for (int lo = 1; lo < 16; lo++) begin
                run_ins(mk(2'(m), 9'(lo * 7), 5'd1, 5'd2), bbase + 64'(lo),
                        64'h0f00_0000_0000_0000, 64'h0, 1'b1, 1'b0, 1'b0);
                run_ins(mk(2'(m), 9'h1f0, 5'd31, 5'd2), bbase,
                        64'h0f00_0000_0000_0000, 64'h100 + 64'(lo), 1'b1, 1'b0, 1'b0);
            end

        // R2: feature disabled, aligned and misaligned
        for (int m = 1; m < 4; m++) begin
            run_ins(mk(2'(m), 9'd3, 5'd1, 5'd2), bbase, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0);
            run_ins(mk(2'(m), 9'd3, 5'd1, 5'd2), bbase + 64'd5, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0);
        end

        // R1: mode 00 and foreign opcodes
        for (int i = 0; i < 8; i++) begin
            run_ins(mk(2'b00, 9'(i * 60), 5'd1, 5'd2), bbase, 64'h0, 64'h0, 1'b1, 1'b0, 1'b0);
            run_ins(mk(2'b00, 9'(i), 5'd1, 5'd2), bbase, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0);
            run_ins(mk(2'b11, 9'(i), 5'd1, 5'd2) ^ (32'h1 << (21 + i)), bbase, 64'h0, 64'h0, 1'b1, 1'b0, 1'b0);
        end

        // R10: strobe while busy
        for (int m = 1; m < 4; m++)
            run_ins(mk(2'(m), 9'h101, 5'd6, 5'd6), 64'h0000_0000_0001_0000,
                    64'h0300_0000_0001_0000, 64'h0, 1'b1, 1'b1, 1'b1);

        // R3 wrap-around at the bottom of the address space
        run_ins(mk(2'b11, 9'h100, 5'd1, 5'd2), 64'h10, 64'h0200_0000_0000_0000, 64'h0, 1'b1, 1'b0, 1'b0);
        run_ins(mk(2'b01, 9'h1ff, 5'd1, 5'd2), 64'h0, 64'h0200_0000_0000_0000, 64'h0, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule